// File: doc/BRIEF.md
# Laser Safety Fault Shutdown Controller

This block guards a laser transmitter. Three comparison flags come in from an external measurement stage: output power too high, bias current too high and output power too low. Each flag can be masked on its own. Any unmasked flag sets a fault latch. The latch drives a shutdown gate whose active level is chosen by a polarity bit, and it turns off the enables for the bias and modulation current setters.

The latch stays set until one of two reset events occurs. The first is a power-down/reset pin held high long enough, counted in clock cycles after a two-flop synchronizer. The second is a set-then-clear cycle of a software power-down bit. Either the pin or the software bit being high puts the block in power-down, and so does the pin when undriven, since it is pulled up outside the block.

While in power-down:
- the current enables are off;
- the two signal-conditioner enables are forced to fixed levels;
- the low-power flag is ignored.

The low-power flag stays ignored for a fixed number of cycles after power-down ends. A status input from the signal conditioner passes straight through at all times.

Top module: `laser_safety_ctrl`

## Requirements
- R1: A source whose mask bit is 1 never sets the fault latch. A source whose mask bit is 0 sets it on the next clock edge while the source flag is 1.
- R2: Once set, `fault_latched` stays 1 after every source flag returns to 0, until a reset event from R4 or R6 occurs.
- R3: `gate_out` equals `fault_latched` when `gate_pol` is 0, and equals its inverse when `gate_pol` is 1.
- R4: A reset event occurs when the synchronized `pdr_pin` is high for RST_CYC consecutive cycles. That event clears the latch.
- R5: A `pdr_pin` high pulse shorter than RST_CYC cycles causes power-down but leaves the latch set.
- R6: A 1-to-0 transition of `soft_pdr` is a reset event and clears the latch.
- R7: While the synchronized `pdr_pin` or `soft_pdr` is 1, `pwr_down` is 1 and `bias_en` and `mod_en` are 0.
- R8: While the latch is set, `bias_en` and `mod_en` are 0. When power-down has ended and the latch is clear, both are 1.
- R9: During power-down, `en1_out` is 1 and `en2_out` is 0. Otherwise they follow `en1_reg` and `en2_reg`.
- R10: `rx_los_out` follows `sc_rx_los` at all times, including during power-down.
- R11: The low-power flag cannot set the latch during power-down, or for BLANK_CYC cycles after power-down ends. After that it can.
- R12: The high-power and high-bias flags set the latch even during power-down.
- R13: A fault source that is active in the same cycle as a reset event wins, and the latch stays 1.
- R14: After `rst_n`, the synchronizer holds the power-down state and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pdr_pin | input | 1 | Asynchronous power-down/reset pin, 1 = power-down (pulled up when undriven) |
| soft_pdr | input | 1 | Software power-down/reset bit |
| flag_hi_pwr | input | 1 | High output-power flag |
| flag_hi_bias | input | 1 | High bias-current flag |
| flag_lo_pwr | input | 1 | Low output-power flag |
| mask_hi_pwr | input | 1 | 1 = ignore high-power flag |
| mask_hi_bias | input | 1 | 1 = ignore high-bias flag |
| mask_lo_pwr | input | 1 | 1 = ignore low-power flag |
| gate_pol | input | 1 | Shutdown gate polarity select |
| en1_reg | input | 1 | Register value for signal-conditioner enable 1 |
| en2_reg | input | 1 | Register value for signal-conditioner enable 2 |
| sc_rx_los | input | 1 | Receive-loss status from signal conditioner |
| gate_out | output | 1 | Shutdown gate drive |
| fault_latched | output | 1 | Latched safety fault |
| pwr_down | output | 1 | Power-down active |
| bias_en | output | 1 | Bias current setter enable |
| mod_en | output | 1 | Modulation current setter enable |
| en1_out | output | 1 | Signal-conditioner enable 1 |
| en2_out | output | 1 | Signal-conditioner enable 2 |
| rx_los_out | output | 1 | Receive-loss status pass-through |

## Verification
The bench builds the block with RST_CYC = 6 and BLANK_CYC = 10. With these small values, pulses just under and well over the qualification width, and the whole blanking window after power-up, can each be driven in a few dozen cycles. Keeping a high-bias flag active across a full qualified pulse places a fault on the exact cycle the reset completes, which exercises the priority rule.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef struct packed {
    logic lo_pwr;
    logic hi_bias;
    logic hi_pwr;
  } lsc_src_t;

  function automatic logic lsc_any_src(lsc_src_t flags, lsc_src_t masks,
                                       logic lo_blank);
    return (flags.hi_pwr  & ~masks.hi_pwr)  |
           (flags.hi_bias & ~masks.hi_bias) |
           (flags.lo_pwr  & ~masks.lo_pwr & ~lo_blank);
  endfunction
endpackage

// File: rtl/lsc_sync.sv
module lsc_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= RST_VAL;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsc_rst_qual.sv
module lsc_rst_qual #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s_i,
  input  logic soft_i,
  output logic clr_o
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] FULL = CW'(RST_CYC);

  logic [CW-1:0] hi_cnt_q;
  logic          soft_q;
  logic          pin_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt_q <= '0;
      soft_q   <= 1'b0;
    end else begin
      soft_q <= soft_i;
      if (!pin_s_i) hi_cnt_q <= '0;
      else if (hi_cnt_q != FULL) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign pin_done = pin_s_i && (hi_cnt_q == LAST);
  assign clr_o    = pin_done || (soft_q && !soft_i);

  // R5: a qualified pin event never occurs while the pin is low
  p_clr_needs_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pin_done |-> pin_s_i && $past(pin_s_i));
endmodule

// File: rtl/lsc_blank.sv
module lsc_blank #(
  parameter int BLANK_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_i,
  output logic blank_o
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam logic [BW-1:0] LOAD = BW'(BLANK_CYC);

  logic [BW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= LOAD;
    else if (pd_i) left_q <= LOAD;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign blank_o = pd_i || (left_q != '0);

  p_blank_after_pd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_i) |-> blank_o);
endmodule

// File: rtl/lsc_fault_latch.sv
module lsc_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_o <= 1'b0;
    else if (set_i) fault_o <= 1'b1;
    else if (clr_i) fault_o <= 1'b0;
  end

  p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> fault_o);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_o) |-> $past(clr_i));
endmodule

// File: rtl/laser_safety_ctrl.sv
module laser_safety_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYC     = 16,
  parameter int BLANK_CYC   = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdr_pin,
  input  logic soft_pdr,
  input  logic flag_hi_pwr,
  input  logic flag_hi_bias,
  input  logic flag_lo_pwr,
  input  logic mask_hi_pwr,
  input  logic mask_hi_bias,
  input  logic mask_lo_pwr,
  input  logic gate_pol,
  input  logic en1_reg,
  input  logic en2_reg,
  input  logic sc_rx_los,
  output logic gate_out,
  output logic fault_latched,
  output logic pwr_down,
  output logic bias_en,
  output logic mod_en,
  output logic en1_out,
  output logic en2_out,
  output logic rx_los_out
);
  import lsc_pkg::*;

  logic     pin_s, clr_evt, lo_blank, src_hit;
  lsc_src_t flags, masks;

  assign flags = '{lo_pwr: flag_lo_pwr, hi_bias: flag_hi_bias, hi_pwr: flag_hi_pwr};
  assign masks = '{lo_pwr: mask_lo_pwr, hi_bias: mask_hi_bias, hi_pwr: mask_hi_pwr};

  lsc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pdr_pin), .q_o(pin_s));

  lsc_rst_qual #(.RST_CYC(RST_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .pin_s_i(pin_s), .soft_i(soft_pdr), .clr_o(clr_evt));

  assign pwr_down = pin_s | soft_pdr;

  lsc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .pd_i(pwr_down), .blank_o(lo_blank));

  assign src_hit = lsc_any_src(flags, masks, lo_blank);

  lsc_fault_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(src_hit), .clr_i(clr_evt), .fault_o(fault_latched));

  assign gate_out   = gate_pol ? ~fault_latched : fault_latched;
  assign bias_en    = ~pwr_down & ~fault_latched;
  assign mod_en     = ~pwr_down & ~fault_latched;
  assign en1_out    = pwr_down ? 1'b1 : en1_reg;
  assign en2_out    = pwr_down ? 1'b0 : en2_reg;
  assign rx_los_out = sc_rx_los;

  p_set_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past((flag_hi_pwr & ~mask_hi_pwr) |
                                   (flag_hi_bias & ~mask_hi_bias) |
                                   (flag_lo_pwr & ~mask_lo_pwr)));
  p_pd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !bias_en && !mod_en);
  p_fault_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !bias_en && !mod_en);
  p_sc_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> en1_out && !en2_out);
  p_hi_in_pd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && flag_hi_bias && !mask_hi_bias) |=> fault_latched);
endmodule

// File: tb/laser_safety_ctrl_tb.sv
module laser_safety_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int RST_C = 6;
  localparam int BLK_C = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pdr_pin = 1'b1, soft_pdr = 1'b0;
  logic f_hp = 0, f_hb = 0, f_lp = 0, m_hp = 0, m_hb = 0, m_lp = 0;
  logic gate_pol = 0, en1_reg = 0, en2_reg = 1, sc_rx_los = 0;
  logic gate_out, fault_latched, pwr_down, bias_en, mod_en, en1_out, en2_out, rx_los_out;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  laser_safety_ctrl #(.SYNC_STAGES(2), .RST_CYC(RST_C), .BLANK_CYC(BLK_C)) dut_i (
    .clk(clk), .rst_n(rst_n), .pdr_pin(pdr_pin), .soft_pdr(soft_pdr),
    .flag_hi_pwr(f_hp), .flag_hi_bias(f_hb), .flag_lo_pwr(f_lp),
    .mask_hi_pwr(m_hp), .mask_hi_bias(m_hb), .mask_lo_pwr(m_lp),
    .gate_pol(gate_pol), .en1_reg(en1_reg), .en2_reg(en2_reg), .sc_rx_los(sc_rx_los),
    .gate_out(gate_out), .fault_latched(fault_latched), .pwr_down(pwr_down),
    .bias_en(bias_en), .mod_en(mod_en), .en1_out(en1_out), .en2_out(en2_out),
    .rx_los_out(rx_los_out));

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic pin_pulse(int n);
    pdr_pin = 1'b1; cyc(n); pdr_pin = 1'b0; cyc(4);
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R14", "pwr_down", pwr_down, 1'b1);
    chk("R14", "fault", fault_latched, 1'b0);
    chk("R7", "bias_en in pd", bias_en, 1'b0);
    chk("R9", "en1 forced", en1_out, 1'b1);
    chk("R9", "en2 forced", en2_out, 1'b0);
    pdr_pin = 1'b0; cyc(4);
    chk("R8", "bias_en resume", bias_en, 1'b1);
    chk("R8", "mod_en resume", mod_en, 1'b1);
    chk("R9", "en1 follows reg", en1_out, 1'b0);
    chk("R9", "en2 follows reg", en2_out, 1'b1);
  endtask

  task automatic t_mask_latch();
    m_hp = 1; f_hp = 1; cyc(3);
    chk("R1", "masked source", fault_latched, 1'b0);
    m_hp = 0; cyc(1);
    chk("R1", "unmasked source", fault_latched, 1'b1);
    f_hp = 0; cyc(5);
    chk("R2", "held after source gone", fault_latched, 1'b1);
    chk("R8", "bias_en off by latch", bias_en, 1'b0);
    chk("R8", "mod_en off by latch", mod_en, 1'b0);
    chk("R3", "gate pol0", gate_out, 1'b1);
    gate_pol = 1; cyc(1);
    chk("R3", "gate pol1", gate_out, 1'b0);
    gate_pol = 0;
  endtask

  task automatic t_pulses();
    pdr_pin = 1'b1; cyc(3);
    chk("R5", "short pulse pwr_down", pwr_down, 1'b1);
    cyc(RST_C - 5); pdr_pin = 1'b0; cyc(4);
    chk("R5", "short pulse keeps latch", fault_latched, 1'b1);
    pin_pulse(RST_C + 4);
    chk("R4", "long pulse clears", fault_latched, 1'b0);
    chk("R8", "resume after clear", bias_en, 1'b1);
    chk("R3", "gate idle pol0", gate_out, 1'b0);
  endtask

  task automatic t_soft();
    f_hb = 1; cyc(1); f_hb = 0; cyc(1);
    chk("R1", "bias source sets", fault_latched, 1'b1);
    soft_pdr = 1; cyc(2);
    chk("R7", "soft pd bias_en", bias_en, 1'b0);
    chk("R7", "soft pd flag", pwr_down, 1'b1);
    chk("R9", "soft pd en1", en1_out, 1'b1);
    sc_rx_los = 1; #1;
    chk("R10", "los in pd hi", rx_los_out, 1'b1);
    sc_rx_los = 0; #1;
    chk("R10", "los in pd lo", rx_los_out, 1'b0);
    chk("R6", "latch held while soft set", fault_latched, 1'b1);
    soft_pdr = 0; cyc(2);
    chk("R6", "soft toggle clears", fault_latched, 1'b0);
    chk("R8", "soft resume", mod_en, 1'b1);
  endtask

  task automatic t_blank();
    pdr_pin = 1'b1; f_lp = 1; cyc(5);
    chk("R11", "lo ignored in pd", fault_latched, 1'b0);
    pdr_pin = 1'b0; cyc(BLK_C - 4);
    chk("R11", "lo ignored in window", fault_latched, 1'b0);
    cyc(10);
    chk("R11", "lo active after window", fault_latched, 1'b1);
    f_lp = 0;
    pin_pulse(RST_C + 4);
    chk("R4", "clear after lo", fault_latched, 1'b0);
  endtask

  task automatic t_hi_pd_prio();
    pdr_pin = 1'b1; cyc(3); f_hp = 1; cyc(1); f_hp = 0; cyc(1);
    chk("R12", "hi source in pd", fault_latched, 1'b1);
    pdr_pin = 1'b0; cyc(4);
    pin_pulse(RST_C + 4);
    chk("R4", "clear hi pd", fault_latched, 1'b0);
    f_hb = 1;
    pin_pulse(RST_C + 4);
    chk("R13", "fault beats reset", fault_latched, 1'b1);
    f_hb = 0;
    pin_pulse(RST_C + 4);
    chk("R13", "clears once source gone", fault_latched, 1'b0);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1;
    t_reset();
    t_mask_latch();
    t_pulses();
    t_soft();
    t_blank();
    t_hi_pd_prio();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule